// File: doc/BRIEF.md
# Tile-Palette Pixel Generator

This block turns raster position into 8-bit colour for a 640x480 screen. It works with a pixel enable that fires every second cycle of a 50 MHz clock, which gives a 25 MHz pixel rate. The screen is cut into 16x16-pixel tiles. Each tile owns four colours picked from the 256 values an 8-bit pixel can take, so every pixel costs only a 2-bit index into its tile's colours.

An external timing generator supplies the horizontal and vertical counters and a blank flag. The block drives a byte-wide read port into display memory, and that memory returns data in the same pixel slot. For each 16-pixel span the block reads four bitmap bytes one span ahead. During the horizontal blanking of the line before a tile band begins, it reloads an on-chip colour store that holds four colours for every tile across the line.

Top module: `tilepal_pixgen`

## Requirements
- R1: While `rst_n` is low, `rgb_o` is 0.
- R2: After an enabled edge where `blank` was high, `rgb_o` is 0.
- R3: After an enabled edge that sampled an active position (h,v), `rgb_o` equals the colour store byte at tile h/16, entry idx. That byte was loaded from address `PAL_BASE + (v/16)*4*TILES_X + 4*(h/16) + idx`.
- R4: The index idx is taken from bitmap byte `v*4*TILES_X + 4*(h/16) + (h%16)/4`. Its bits [7:6] give the first of the four pixels in that byte, and bits [1:0] give the last.
- R5: In the line's active part, `mem_rd` is high exactly when h%16 is 0 to 3. The address then points to byte h%4 of the next tile in the same line. In the last span of the line, it points instead to tile 0 of the following line (line 0 after line V_TOTAL-1).
- R6: If the following line starts a band (line%16==0) and lies inside the 480 active lines, there are 4*TILES_X reads at h = H_ACTIVE + j. Each uses address `PAL_BASE + band*4*TILES_X + j`, and its byte fills tile j/4, entry j%4.
- R7: When `pix_en` is low, `mem_rd` is 0 and `rgb_o` keeps its value.
- R8: Every line has 4*TILES_X reads, plus another 4*TILES_X on lines that reload the colour store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset, already synchronised |
| pix_en | input | 1 | Pixel-rate clock enable |
| hcnt | input | HCW | Horizontal position from timing generator |
| vcnt | input | VCW | Vertical position from timing generator |
| blank | input | 1 | High outside the visible area |
| mem_rd | output | 1 | Display memory read strobe |
| mem_addr | output | ADDR_W | Display memory byte address |
| mem_rdata | input | 8 | Byte returned for `mem_addr` in the same slot |
| rgb_o | output | 8 | Registered colour, red [7:6] green [5:3] blue [2:0] |

## Verification
The bench builds the block with two tiles across and two tile bands down. Lines are 44 pixels long and there are 36 lines per frame. With these values, two complete frames step through every pixel of both bands. They also cover the wrap from the last span to tile 0 of the next line, the wrap from the last frame line to line 0, and both colour-store reloads, each with its full blanking window. Each pixel colour, read strobe and address is computed from address arithmetic on a synthetic memory pattern.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int TILE_LOG   = 4;
  localparam int TILE_PX    = 1 << TILE_LOG;
  localparam int IDX_BITS   = 2;
  localparam int SPAN_BYTES = TILE_PX * IDX_BITS / 8;
  localparam int TILE_COLS  = 1 << IDX_BITS;
  typedef logic [7:0] pix_t;
  typedef logic [IDX_BITS-1:0] cidx_t;
endpackage

// File: rtl/tp_fetch_sched.sv
module tp_fetch_sched
  import tp_pkg::*;
#(
  parameter int TILES_X  = 40,
  parameter int TILES_Y  = 30,
  parameter int H_TOTAL  = 800,
  parameter int V_TOTAL  = 525,
  parameter int HCW      = 10,
  parameter int VCW      = 10,
  parameter int ADDR_W   = 17,
  parameter int PAL_BASE = 76800,
  parameter int PIW      = 8
) (
  input  logic              pix_en,
  input  logic [HCW-1:0]    hcnt,
  input  logic [VCW-1:0]    vcnt,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              bm_we,
  output logic [1:0]        bm_slot,
  output logic              pal_we,
  output logic [PIW-1:0]    pal_widx
);
  localparam int H_ACTIVE   = TILES_X * TILE_PX;
  localparam int V_ACTIVE   = TILES_Y * TILE_PX;
  localparam int LINE_BYTES = TILES_X * SPAN_BYTES;
  localparam int TW         = HCW - TILE_LOG;

  logic [VCW-1:0]    next_line, f_line;
  logic [TW-1:0]     tile, f_tile;
  logic [HCW-1:0]    rj;
  logic [ADDR_W-1:0] bm_addr, pal_addr;
  logic in_act_h, last_span, fetch_slot, refill_line, refill_slot;

  always_comb begin
    next_line   = (vcnt == VCW'(V_TOTAL - 1)) ? '0 : vcnt + 1'b1;
    in_act_h    = hcnt < HCW'(H_ACTIVE);
    tile        = hcnt[HCW-1:TILE_LOG];
    last_span   = tile == TW'(TILES_X - 1);
    fetch_slot  = in_act_h && (hcnt[TILE_LOG-1:2] == '0);
    f_line      = last_span ? next_line : vcnt;
    f_tile      = last_span ? '0 : tile + 1'b1;
    bm_addr     = ADDR_W'(f_line) * ADDR_W'(LINE_BYTES)
                + ADDR_W'(f_tile) * ADDR_W'(SPAN_BYTES)
                + ADDR_W'(hcnt[1:0]);
    rj          = hcnt - HCW'(H_ACTIVE);
    refill_line = (next_line[TILE_LOG-1:0] == '0) && (next_line < VCW'(V_ACTIVE));
    refill_slot = !in_act_h && refill_line && (rj < HCW'(LINE_BYTES));
    pal_addr    = ADDR_W'(PAL_BASE)
                + ADDR_W'(next_line[VCW-1:TILE_LOG]) * ADDR_W'(LINE_BYTES)
                + ADDR_W'(rj);
  end

  assign mem_rd   = pix_en && (fetch_slot || refill_slot);
  assign mem_addr = fetch_slot ? bm_addr : pal_addr;
  assign bm_we    = pix_en && fetch_slot;
  assign bm_slot  = hcnt[1:0];
  assign pal_we   = pix_en && refill_slot;
  assign pal_widx = rj[PIW-1:0];
endmodule

// File: rtl/tp_bitmap_shift.sv
module tp_bitmap_shift
  import tp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_en,
  input  logic       bm_we,
  input  logic [1:0] bm_slot,
  input  pix_t       bm_byte,
  input  logic       span_start,
  output cidx_t      cidx
);
  localparam int SH_W = SPAN_BYTES * 8;

  pix_t            lane_q [SPAN_BYTES];
  logic [SH_W-1:0] sh_q, sh_d;

  for (genvar k = 0; k < SPAN_BYTES; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               lane_q[k] <= '0;
      else if (bm_we && bm_slot == 2'(k))       lane_q[k] <= bm_byte;
    end
  end

  always_comb begin
    if (span_start) begin
      cidx = lane_q[0][7:6];
      sh_d = {lane_q[0][5:0], lane_q[1], lane_q[2], lane_q[3], 2'b00};
    end else begin
      cidx = sh_q[SH_W-1 -: 2];
      sh_d = {sh_q[SH_W-3:0], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (pix_en) sh_q <= sh_d;
  end
endmodule

// File: rtl/tp_color_store.sv
module tp_color_store
  import tp_pkg::*;
#(
  parameter int TILES_X = 40,
  parameter int PIW     = 8
) (
  input  logic           clk,
  input  logic           we,
  input  logic [PIW-1:0] widx,
  input  pix_t           wdata,
  input  logic [PIW-1:0] ridx,
  output pix_t           rdata
);
  localparam int ENTRIES = TILES_X * TILE_COLS;

  pix_t ent [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && widx == PIW'(e)) ent[e] <= wdata;
    end
  end

  assign rdata = ent[ridx];
endmodule

// File: rtl/tilepal_pixgen.sv
module tilepal_pixgen
  import tp_pkg::*;
#(
  parameter int TILES_X  = 40,
  parameter int TILES_Y  = 30,
  parameter int H_TOTAL  = 800,
  parameter int V_TOTAL  = 525,
  parameter int HCW      = 10,
  parameter int VCW      = 10,
  parameter int ADDR_W   = 17,
  parameter int PAL_BASE = 76800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [HCW-1:0]    hcnt,
  input  logic [VCW-1:0]    vcnt,
  input  logic              blank,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        rgb_o
);
  localparam int PIW = $clog2(TILES_X * TILE_COLS);
  localparam int TW  = HCW - TILE_LOG;

  logic           bm_we, pal_we, span_start;
  logic [1:0]     bm_slot;
  logic [PIW-1:0] pal_widx, rd_idx;
  logic [TW-1:0]  rd_tile;
  cidx_t          cidx;
  pix_t           pal_rd, rgb_d, rgb_q;

  tp_fetch_sched #(
    .TILES_X(TILES_X), .TILES_Y(TILES_Y), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
    .HCW(HCW), .VCW(VCW), .ADDR_W(ADDR_W), .PAL_BASE(PAL_BASE), .PIW(PIW)
  ) u_sched (
    .pix_en(pix_en), .hcnt(hcnt), .vcnt(vcnt), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .bm_we(bm_we), .bm_slot(bm_slot), .pal_we(pal_we), .pal_widx(pal_widx)
  );

  assign span_start = hcnt[TILE_LOG-1:0] == '0;

  tp_bitmap_shift u_shift (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .bm_we(bm_we), .bm_slot(bm_slot),
    .bm_byte(mem_rdata), .span_start(span_start), .cidx(cidx)
  );

  always_comb begin
    rd_tile = hcnt[HCW-1:TILE_LOG];
    rd_idx  = (rd_tile < TW'(TILES_X)) ? PIW'({rd_tile, cidx}) : '0;
  end

  tp_color_store #(.TILES_X(TILES_X), .PIW(PIW)) u_store (
    .clk(clk), .we(pal_we), .widx(pal_widx), .wdata(mem_rdata),
    .ridx(rd_idx), .rdata(pal_rd)
  );

  always_comb rgb_d = blank ? '0 : pal_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rgb_q <= '0;
    else if (pix_en) rgb_q <= rgb_d;
  end

  assign rgb_o = rgb_q;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int TILES_X  = 40,
  parameter int HCW      = 10,
  parameter int ADDR_W   = 17,
  parameter int PAL_BASE = 76800
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_en,
  input logic [HCW-1:0]    hcnt,
  input logic              blank,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        rgb_o
);
  localparam int H_ACTIVE = TILES_X * 16;

  a_r2_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && blank |=> rgb_o == 8'd0);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(rgb_o));

  a_r7_no_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |-> !mem_rd);

  a_r6_refill_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && hcnt >= HCW'(H_ACTIVE) |-> blank && mem_addr >= ADDR_W'(PAL_BASE));

  a_r5_fetch_slots: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && hcnt < HCW'(H_ACTIVE) |-> hcnt[3:2] == 2'b00);
endmodule

bind tilepal_pixgen tp_checker #(
  .TILES_X(TILES_X), .HCW(HCW), .ADDR_W(ADDR_W), .PAL_BASE(PAL_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hcnt(hcnt), .blank(blank),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .rgb_o(rgb_o)
);

// File: tb/tb_tilepal_pixgen.sv
`timescale 1ns/1ps
module tb_tilepal_pixgen;
  localparam int TX = 2, TY = 2, HT = 44, VT = 36, HCW = 6, VCW = 6, AW = 9;
  localparam int HA = TX * 16, VA = TY * 16, LB = TX * 4, PB = VA * LB;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, pix_en, blank, mem_rd;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic [AW-1:0]  mem_addr;
  logic [7:0]     mem_rdata, rgb_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  tilepal_pixgen #(
    .TILES_X(TX), .TILES_Y(TY), .H_TOTAL(HT), .V_TOTAL(VT),
    .HCW(HCW), .VCW(VCW), .ADDR_W(AW), .PAL_BASE(PB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hcnt(hcnt), .vcnt(vcnt),
    .blank(blank), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rgb_o(rgb_o)
  );

  function automatic logic [7:0] mfun(int a);
    return 8'((a * 73) ^ (a >> 2) ^ 90);
  endfunction

  assign mem_rdata = mfun(int'(mem_addr));

  function automatic int exp_pix(int h, int v);
    int o, b, idx;
    if (h >= HA || v >= VA) return 0;
    o   = h % 16;
    b   = mfun(v * LB + (h / 16) * 4 + o / 4);
    idx = (b >> (6 - 2 * (o % 4))) & 3;
    return mfun(PB + (v / 16) * LB + (h / 16) * 4 + idx);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, nl, er, ea, reads, saved, refill;
    rst_n = 1'b0; pix_en = 1'b0; hcnt = '0; vcnt = '0; blank = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rgb_o == 8'd0, "R1 reset rgb", int'(rgb_o), 0);
    rst_n = 1'b1;
    saved = 0;
    v = VT - 1;
    for (int ln = 0; ln <= 2 * VT; ln++) begin
      reads = 0;
      nl = (v == VT - 1) ? 0 : v + 1;
      refill = (nl % 16 == 0 && nl < VA) ? 1 : 0;
      for (int h = 0; h < HT; h++) begin
        @(negedge clk);
        check(int'(rgb_o) == saved, "R7 hold while idle", int'(rgb_o), saved);
        hcnt = HCW'(h); vcnt = VCW'(v); blank = (h >= HA || v >= VA);
        pix_en = 1'b1;
        #1;
        er = 0; ea = 0;
        if (h < HA && h % 16 < 4) begin
          int t, l;
          t = h / 16 + 1; l = v;
          if (t == TX) begin t = 0; l = nl; end
          er = 1; ea = l * LB + t * 4 + h % 4;
        end else if (h >= HA && h - HA < LB && refill == 1) begin
          er = 1; ea = PB + (nl / 16) * LB + (h - HA);
        end
        check(int'(mem_rd) == er, h < HA ? "R5 read strobe" : "R6 read strobe", int'(mem_rd), er);
        if (er == 1 && mem_rd)
          check(int'(mem_addr) == ea, h < HA ? "R5 bitmap addr" : "R6 refill addr", int'(mem_addr), ea);
        if (mem_rd) reads++;
        @(posedge clk);
        @(negedge clk);
        if (h >= HA || v >= VA)
          check(rgb_o == 8'd0, "R2 blank output", int'(rgb_o), 0);
        else
          check(int'(rgb_o) == exp_pix(h, v), "R3 R4 pixel colour", int'(rgb_o), exp_pix(h, v));
        saved = int'(rgb_o);
        pix_en = 1'b0;
        #1;
        check(mem_rd == 1'b0, "R7 no read idle", int'(mem_rd), 0);
      end
      check(reads == LB * (1 + refill), "R8 reads per line", reads, LB * (1 + refill));
      v = nl;
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule